// File: doc/BRIEF.md
# Sleep Timer with Rollover Watchdog

This block keeps a free-running sleep timer that advances on a slow-clock enable strobe and wraps after one of four selectable interval lengths. Each wrap (a rollover) can raise a pending sleep interrupt, gated by an enable bit in an 8-bit mask register. The interrupt stays pending until software acknowledges it.

The watchdog has no counter of its own. It counts sleep-timer rollovers and fires a one-cycle reset pulse on the third rollover after the last clear. Software restarts it by writing anything to a write-only clear register. One key value, 0x38, also restarts the sleep timer, so the next watchdog reset is a full three intervals away. Any other value leaves the timer running, so the reset lands between two and three intervals later.

Top module: `sleep_wdog_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_pend` and `wdt_rst` are 0, and the mask register and sleep timer hold 0.
- R2: The sleep timer advances only on cycles with `tick_en` high. It wraps after 2^(BASE_LOG2 + STEP_LOG2*`interval_sel`) ticks. With the default parameters that is 64, 512, 4096 or 32768 ticks for select values 0 to 3.
- R3: A write with `wr_addr`=0 loads the mask register. Bit 6 of `wr_data` is the sleep-interrupt enable. A rollover sets `irq_pend` on the next cycle only when that bit is 1. With the bit at 0, rollovers leave `irq_pend` low.
- R4: `irq_pend` stays high until a cycle with `irq_ack` high clears it. If an enabled rollover falls on the same cycle as `irq_ack`, `irq_pend` stays high.
- R5: A write with `wr_addr`=1 and any data restarts the watchdog rollover count. A value other than 0x38 leaves the sleep timer count undisturbed.
- R6: A write with `wr_addr`=1 and data 0x38 restarts both the watchdog rollover count and the sleep timer count.
- R7: `wdt_rst` is a one-cycle pulse. It is high in the cycle after the edge that carries the third counted rollover since the last clear or reset.
- R8: After a clear that is not 0x38, the pulse comes 2N to 3N timer ticks later, where N is the interval length. After a 0x38 clear it comes exactly 3N ticks later.
- R9: When a clear write and a rollover fall on the same cycle, the clear wins and that rollover is not counted.
- R10: The edge that raises `wdt_rst` returns the sleep timer, the rollover count and the mask register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow-clock enable strobe that advances the sleep timer |
| interval_sel | input | 2 | Selects the sleep interval length |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mask register, 1 selects the clear register |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Acknowledge that clears the pending sleep interrupt |
| irq_pend | output | 1 | Pending sleep interrupt |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
On every cycle the embedded properties check these rules:
- the reset pulse is never wider than one cycle;
- a clear leaves the rollover count at zero and blocks a pulse in the following cycle;
- the timer holds still without a tick;
- the key value zeroes the timer;
- the pending flag follows the set, hold and acknowledge rules;
- the firing edge drops the interrupt enable.

Only the bench scenarios can show the absolute timing. They cover:
- the reset falling exactly three intervals after reset for every interval select;
- the half-rate strobe stretching that time;
- the 2N-to-3N window of a plain clear, swept over every timer position;
- the 3N window of a key-value clear;
- the rollover-versus-clear priority;
- the second watchdog period that follows a self-reset.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam logic       REG_MASK       = 1'b0;
  localparam logic       REG_CLEAR      = 1'b1;
  localparam logic [7:0] BOTH_CLEAR_KEY = 8'h38;
  localparam int         SLEEP_EN_BIT   = 6;
endpackage

// File: rtl/sw_sleep_timer.sv
module sw_sleep_timer #(
  parameter int BASE_LOG2 = 6,
  parameter int STEP_LOG2 = 3,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic             wd_fire,
  output logic             roll
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim [NSEL];

  // terminal count per select value: the all-ones value shortened by whole steps
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim[g] = {CNT_W{1'b1}} >> (STEP_LOG2 * (NSEL - 1 - g));
  end

  assign roll = tick_en && (cnt >= lim[sel]);

  always_ff @(posedge clk) begin
    if (rst || wd_fire || restart) cnt <= '0;
    else if (tick_en)              cnt <= roll ? '0 : cnt + 1'b1;
  end

  // R2: no strobe, no restart, no fire -> timer holds
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !restart && !wd_fire) |=> cnt == $past(cnt));
  // R6: key-value clear zeroes the timer
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0);
  // R10: watchdog fire zeroes the timer
  a_r10_fire_zero: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> cnt == '0);
endmodule

// File: rtl/sw_roll_wdog.sv
module sw_roll_wdog #(
  parameter int FIRE_AT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic roll,
  input  logic clr,
  output logic fire,
  output logic wd_pulse
);
  localparam int CW = $clog2(FIRE_AT + 1);

  logic [CW-1:0] count;

  assign fire = roll && !clr && (count == CW'(FIRE_AT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      wd_pulse <= 1'b0;
    end else begin
      wd_pulse <= fire;
      if (clr || fire) count <= '0;
      else if (roll)   count <= count + 1'b1;
    end
  end

  // R7: pulse is exactly one cycle wide
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wd_pulse |=> !wd_pulse);
  // R7: count never reaches the firing value while held
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count < CW'(FIRE_AT));
  // R9: a clear wins over a coincident rollover
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0) && !wd_pulse);
  // R10: the pulse coincides with a restarted count
  a_r10_count_restarted: assert property (@(posedge clk) disable iff (rst)
    wd_pulse |-> count == '0);
endmodule

// File: rtl/sw_irq_ctrl.sv
module sw_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wd_fire,
  input  logic mask_we,
  input  logic mask_bit,
  input  logic roll,
  input  logic ack,
  output logic pend
);
  logic sleep_en;
  logic set_req;

  assign set_req = roll && sleep_en;

  always_ff @(posedge clk) begin
    if (rst || wd_fire) sleep_en <= 1'b0;
    else if (mask_we)   sleep_en <= mask_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (set_req) pend <= 1'b1;
    else if (ack)     pend <= 1'b0;
  end

  // R4: enabled rollover sets the flag, even against an acknowledge
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    (roll && sleep_en) |=> pend);
  // R4: without acknowledge the flag holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);
  // R3: no enabled rollover, no new flag
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!pend && !(roll && sleep_en)) |=> !pend);
  // R10: watchdog fire drops the interrupt enable
  a_r10_mask_cleared: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> !sleep_en);
endmodule

// File: rtl/sleep_wdog_top.sv
module sleep_wdog_top #(
  parameter int BASE_LOG2 = 6,
  parameter int STEP_LOG2 = 3,
  parameter int FIRE_AT   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic [1:0] interval_sel,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       irq_ack,
  output logic       irq_pend,
  output logic       wdt_rst
);
  import sw_pkg::*;

  logic roll, fire, clr_wr, restart, mask_we;

  assign clr_wr  = wr_en && (wr_addr == REG_CLEAR);
  assign restart = clr_wr && (wr_data == BOTH_CLEAR_KEY);
  assign mask_we = wr_en && (wr_addr == REG_MASK);

  sw_sleep_timer #(
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .SEL_W(2)
  ) u_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sel(interval_sel),
    .restart(restart), .wd_fire(fire), .roll(roll)
  );

  sw_roll_wdog #(.FIRE_AT(FIRE_AT)) u_wdog (
    .clk(clk), .rst(rst), .roll(roll), .clr(clr_wr),
    .fire(fire), .wd_pulse(wdt_rst)
  );

  sw_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .wd_fire(fire), .mask_we(mask_we),
    .mask_bit(wr_data[SLEEP_EN_BIT]), .roll(roll), .ack(irq_ack),
    .pend(irq_pend)
  );

  // R1: outputs are quiet in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !irq_pend && !wdt_rst);
endmodule

// File: tb/sim_sleep_wdog_top.sv
`timescale 1ns/1ps
module sim_sleep_wdog_top;
  localparam int BASE = 2;
  localparam int STEP = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b1;
  logic [1:0] interval_sel = 2'd0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq_ack = 1'b0;
  logic irq_pend, wdt_rst;

  int checks = 0, errors = 0;
  int edge_n = 0, first_fire = 0, last_fire = 0, fire_cnt = 0;
  bit half = 1'b0;

  always #2.5 clk = ~clk;

  sleep_wdog_top #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .FIRE_AT(3)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .interval_sel(interval_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_ack(irq_ack),
    .irq_pend(irq_pend), .wdt_rst(wdt_rst)
  );

  function automatic int ilen(int s);
    return 1 << (BASE + STEP * s);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    edge_n++;
    if (wdt_rst) begin
      fire_cnt++;
      last_fire = edge_n;
      if (first_fire == 0) first_fire = edge_n;
    end
    tick_en = half ? ((edge_n + 1) % 2 == 1) : 1'b1;
  endtask

  task automatic do_reset(int s);
    interval_sel = 2'(s);
    rst = 1'b1;
    half = 1'b0;
    tick_en = 1'b1;
    step();
    step();
    rst = 1'b0;
    edge_n = 0; first_fire = 0; last_fire = 0; fire_cnt = 0;
    if (half) tick_en = 1'b1;
  endtask

  task automatic advance_to(int t);
    while (edge_n < t) step();
  endtask

  task automatic do_write(logic a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    do_reset(0);
    chk("R1 irq_pend after reset", int'(irq_pend), 0);
    chk("R1 wdt_rst after reset", int'(wdt_rst), 0);

    // R2/R7: untouched watchdog fires on the third rollover, every select
    for (int s = 0; s < 4; s++) begin
      n = ilen(s);
      do_reset(s);
      advance_to(3 * n + 2);
      chk("R2/R7 fire edge", first_fire, 3 * n);
      chk("R7 single pulse", fire_cnt, 1);
      chk("R3 no irq with mask clear", int'(irq_pend), 0);
    end

    // R2: half-rate strobe doubles the time (ticks on odd edges)
    n = ilen(1);
    do_reset(1);
    half = 1'b1;
    tick_en = 1'b1;
    advance_to(6 * n + 2);
    chk("R2 half-rate fire edge", first_fire, 6 * n - 1);
    half = 1'b0;

    // R3/R4: interrupt set, hold, ack, ack against rollover
    n = ilen(0);
    do_reset(0);
    do_write(1'b0, 8'h40);
    advance_to(n - 1);
    chk("R3 pend before rollover", int'(irq_pend), 0);
    step();
    chk("R3 pend after rollover", int'(irq_pend), 1);
    advance_to(n + 2);
    chk("R4 pend holds", int'(irq_pend), 1);
    do_ack();
    chk("R4 ack clears", int'(irq_pend), 0);
    advance_to(2 * n - 1);
    do_ack();
    chk("R4 rollover beats ack", int'(irq_pend), 1);
    do_ack();
    chk("R4 later ack clears", int'(irq_pend), 0);

    // R3: enable bit low, other bits high
    do_reset(0);
    do_write(1'b0, 8'hBF);
    advance_to(2 * n + 1);
    chk("R3 masked rollover", int'(irq_pend), 0);

    // R5/R8: plain clear at every timer position
    for (int s = 0; s < 2; s++) begin
      n = ilen(s);
      for (int c = 1; c < n; c++) begin
        do_reset(s);
        advance_to(n + c - 1);
        do_write(1'b1, 8'hA5 ^ 8'(c));
        advance_to(4 * n + 2);
        chk("R5 plain clear fire edge", first_fire, 4 * n);
        chk("R8 plain clear window",
            int'((first_fire - (n + c) >= 2 * n) && (first_fire - (n + c) <= 3 * n)), 1);
      end
    end

    // R6/R8: key clear at every timer position
    for (int s = 0; s < 2; s++) begin
      n = ilen(s);
      for (int c = 1; c < n; c++) begin
        do_reset(s);
        advance_to(n + c - 1);
        do_write(1'b1, 8'h38);
        advance_to(4 * n + c + 2);
        chk("R6/R8 key clear fire edge", first_fire, 4 * n + c);
      end
    end

    // R9: clear on the rollover edge wins
    n = ilen(0);
    for (int k = 1; k <= 2; k++) begin
      do_reset(0);
      advance_to(k * n - 1);
      do_write(1'b1, 8'h11);
      advance_to((k + 3) * n + 2);
      chk("R9 clear beats rollover", first_fire, (k + 3) * n);
    end

    // R10: fire clears mask and timer; next period starts from the fire edge
    n = ilen(0);
    do_reset(0);
    do_write(1'b0, 8'h40);
    advance_to(3 * n);
    chk("R7 pulse high at fire", int'(wdt_rst), 1);
    do_ack();
    chk("R7 pulse gone", int'(wdt_rst), 0);
    advance_to(4 * n + 2);
    chk("R10 mask cleared by fire", int'(irq_pend), 0);
    advance_to(6 * n + 2);
    chk("R10 second fire edge", last_fire, 6 * n);
    chk("R10 fire count", fire_cnt, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule